// File: doc/BRIEF.md
# Serial Audio Output Formatter

This block takes decoded stereo samples, 24 bits per channel, and sends them out on three lines: a bit clock, a word clock and a serial data line. A two-bit format code selects one of four framings. The block runs from a system clock that is a fixed multiple of the sample rate. It divides that clock down to a bit clock at 64 times the sample rate and a word clock at the sample rate, so each channel owns 32 bit slots per sample period. Data always goes out MSB first in two's complement.

Upstream logic presents a sample pair with a one-cycle strobe. The strobe also carries a parity-error flag and a non-PCM flag. On a parity error in PCM data, the block keeps the previous pair instead of taking the corrupt one. Non-PCM payloads pass through untouched even when flagged. While the upstream receiver reports no lock, the data line is forced low, but both clocks keep running. An accepted pair waits in a holding stage. It moves into the output registers at the start of the next left half-frame, so a strobe never disturbs the frame that is already being sent.

Top module: `aud_ser_fmt`

## Requirements
- R1: Format code 2'b10 is 24-bit left-justified: the word MSB is in slot 0 of each 32-slot half and the LSB is in slot 23. Slots 24 to 31 carry 0.
- R2: Format code 2'b11 is I2S: the word MSB is in slot 1 and the LSB is in slot 24. Slot 0 and slots 25 to 31 carry 0.
- R3: Format code 2'b01 is 24-bit right-justified, with the MSB in slot 8, the LSB in slot 31 and 0 in slots 0 to 7. Format code 2'b00 is 16-bit right-justified: word bits 23 down to 8 fill slots 16 to 31, and slots 0 to 15 carry 0.
- R4: The bit clock has a period of BCK_DIV system clocks (default 4) and is high for the second half of each period. Each half-frame lasts 32 bit clocks. The word clock and the data line change only on a falling bit-clock edge.
- R5: In I2S the word clock is low for the left half and high for the right half. In the other three formats it is high for left and low for right. Each frame sends the left half first.
- R6: A strobe with the parity-error flag set and the non-PCM flag low is discarded. The next frame repeats the previously accepted left and right words.
- R7: A strobe with the parity-error flag set and the non-PCM flag high is accepted unchanged.
- R8: When the lock input is low at a clock edge, the data line is low after that edge. Both clocks keep running.
- R9: While reset is low, the bit clock, word clock and data line are low, and the held words are cleared to zero. The first falling bit-clock edge after reset starts slot 0 of a left half.
- R10: An accepted pair is loaded only at the start of a left half. Strobes during a frame do not change that frame. If several strobes arrive within one frame, the last accepted pair is used in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, BCK_DIV times the bit-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe: a new sample pair is present |
| smp_left | input | 24 | Left-channel sample, two's complement |
| smp_right | input | 24 | Right-channel sample, two's complement |
| par_err | input | 1 | Parity error on the strobed pair |
| non_pcm | input | 1 | Strobed pair is a non-PCM payload |
| locked | input | 1 | Upstream receiver is locked |
| fmt_sel | input | 2 | Output framing code |
| bck | output | 1 | Bit clock |
| lrck | output | 1 | Word clock |
| sdata | output | 1 | Serial data |

## Verification
Each result has a fixed due time, and the bench samples at that time. A strobed pair shows up in the frame after the one during which it was strobed. That frame starts at the first falling bit-clock edge after slot 63. A lock drop clears the data line one system clock later, and a lock rise takes effect at the next falling bit-clock edge. The bench captures each slot on the rising bit clock, in the middle of the bit. It changes lock only just after slot 63 has been sampled, so every compared frame is sent under a single lock state. Expected frames go into a queue one frame ahead of their due time, and each completed 64-slot capture takes one item from that queue.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

  localparam int WORD_W    = 24;
  localparam int HALF_SL   = 32;
  localparam int POS_W     = $clog2(HALF_SL);
  localparam int SLOT_W    = POS_W + 1;
  localparam int SHORT_W   = 16;

  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ24 = 2'b01,
    FMT_LJ24 = 2'b10,
    FMT_I2S  = 2'b11
  } fmt_e;

  // Slot at which the MSB of a word lands within a half-frame.
  function automatic int msb_slot(fmt_e f);
    case (f)
      FMT_LJ24: return 0;
      FMT_I2S:  return 1;
      FMT_RJ24: return HALF_SL - WORD_W;
      default:  return HALF_SL - SHORT_W;
    endcase
  endfunction

  // Lowest word bit that is transmitted in a format.
  function automatic int lsb_kept(fmt_e f);
    return (f == FMT_RJ16) ? (WORD_W - SHORT_W) : 0;
  endfunction

  // Data bit for slot position p of a half-frame carrying word w.
  function automatic logic slot_bit(fmt_e f, logic [POS_W-1:0] p,
                                    logic [WORD_W-1:0] w);
    int off;
    int idx;
    logic [WORD_W-1:0] sh;
    off = msb_slot(f);
    idx = WORD_W - 1 - (int'(p) - off);
    if (int'(p) < off || idx < lsb_kept(f)) return 1'b0;
    sh = w >> idx;
    return sh[0];
  endfunction

  // Word-clock level that marks the left channel.
  function automatic logic left_level(fmt_e f);
    return (f != FMT_I2S);
  endfunction

endpackage

// File: rtl/aud_bck_gen.sv
module aud_bck_gen #(
  parameter int BCK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic bck,
  output logic bit_fall
);
  localparam int CNT_W = (BCK_DIV > 2) ? $clog2(BCK_DIV) : 1;
  localparam int HALF  = BCK_DIV / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BCK_DIV - 1);
  localparam logic [CNT_W-1:0] RISE = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  assign bit_fall = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      bck <= 1'b0;
    end else begin
      cnt <= bit_fall ? '0 : cnt + 1'b1;
      if (bit_fall)         bck <= 1'b0;
      else if (cnt == RISE) bck <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_conceal.sv
module aud_conceal
  import aud_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  input  logic              par_err,
  input  logic              non_pcm,
  output logic [WORD_W-1:0] held_left,
  output logic [WORD_W-1:0] held_right,
  output logic              conceal_hit
);
  logic take;

  assign conceal_hit = smp_stb & par_err & ~non_pcm;
  assign take        = smp_stb & ~conceal_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_left  <= '0;
      held_right <= '0;
    end else if (take) begin
      held_left  <= smp_left;
      held_right <= smp_right;
    end
  end
endmodule

// File: rtl/aud_frame_shift.sv
module aud_frame_shift
  import aud_ser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_fall,
  input  logic [1:0]        fmt_sel,
  input  logic              locked,
  input  logic [WORD_W-1:0] held_left,
  input  logic [WORD_W-1:0] held_right,
  output logic              lrck,
  output logic              sdata,
  output logic              frame_start
);
  fmt_e              fmt;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_nxt;
  logic [WORD_W-1:0] cur_l;
  logic [WORD_W-1:0] cur_r;
  logic [WORD_W-1:0] word_now;
  logic              right_half;
  logic              next_bit;

  assign fmt         = fmt_e'(fmt_sel);
  assign slot_nxt    = slot + 1'b1;
  assign right_half  = slot_nxt[SLOT_W-1];
  assign frame_start = bit_fall && (slot_nxt == '0);

  always_comb begin
    if (right_half)       word_now = cur_r;
    else if (frame_start) word_now = held_left;
    else                  word_now = cur_l;
  end

  assign next_bit = slot_bit(fmt, slot_nxt[POS_W-1:0], word_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot  <= '1;
      cur_l <= '0;
      cur_r <= '0;
      lrck  <= 1'b0;
      sdata <= 1'b0;
    end else begin
      if (bit_fall) begin
        slot  <= slot_nxt;
        lrck  <= right_half ? ~left_level(fmt) : left_level(fmt);
        sdata <= locked & next_bit;
      end else begin
        sdata <= sdata & locked;
      end
      if (frame_start) begin
        cur_l <= held_left;
        cur_r <= held_right;
      end
    end
  end
endmodule

// File: rtl/aud_ser_fmt.sv
module aud_ser_fmt
  import aud_ser_pkg::*;
#(
  parameter int BCK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [WORD_W-1:0] smp_left,
  input  logic [WORD_W-1:0] smp_right,
  input  logic              par_err,
  input  logic              non_pcm,
  input  logic              locked,
  input  logic [1:0]        fmt_sel,
  output logic              bck,
  output logic              lrck,
  output logic              sdata
);
  logic              bit_fall;
  logic              frame_start;
  logic              conceal_hit;
  logic [WORD_W-1:0] held_left;
  logic [WORD_W-1:0] held_right;

  aud_bck_gen #(.BCK_DIV(BCK_DIV)) u_bck (
    .clk      (clk),
    .rst_n    (rst_n),
    .bck      (bck),
    .bit_fall (bit_fall)
  );

  aud_conceal u_conceal (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_stb     (smp_stb),
    .smp_left    (smp_left),
    .smp_right   (smp_right),
    .par_err     (par_err),
    .non_pcm     (non_pcm),
    .held_left   (held_left),
    .held_right  (held_right),
    .conceal_hit (conceal_hit)
  );

  aud_frame_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_fall    (bit_fall),
    .fmt_sel     (fmt_sel),
    .locked      (locked),
    .held_left   (held_left),
    .held_right  (held_right),
    .lrck        (lrck),
    .sdata       (sdata),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/aud_ser_chk.sv
module aud_ser_chk
  import aud_ser_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bck,
  input logic              lrck,
  input logic              sdata,
  input logic              locked,
  input logic [1:0]        fmt_sel,
  input logic              frame_start,
  input logic              conceal_hit,
  input logic [WORD_W-1:0] held_left
);
  logic              bck_d;
  logic              lrck_d;
  logic              seen;
  logic [SLOT_W-1:0] fall_cnt;
  logic              fell;
  logic              lr_chg;

  assign fell   = bck_d & ~bck;
  assign lr_chg = lrck_d ^ lrck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d    <= 1'b0;
      lrck_d   <= 1'b0;
      seen     <= 1'b0;
      fall_cnt <= '0;
    end else begin
      bck_d  <= bck;
      lrck_d <= lrck;
      if (fell) begin
        if (lr_chg) begin
          fall_cnt <= '0;
          seen     <= 1'b1;
        end else begin
          fall_cnt <= fall_cnt + 1'b1;
        end
      end
    end
  end

  AST_LRCK_ON_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck) |-> $fell(bck));                                   // R4

  AST_DATA_ON_BCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sdata) && $past(locked)) |-> $fell(bck));               // R4

  AST_HALF_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (fell && lr_chg && seen) |-> (fall_cnt == SLOT_W'(HALF_SL - 1))); // R4

  AST_LEFT_LEVEL_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (lrck == (fmt_sel != 2'b11)));                    // R5

  AST_CONCEAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    conceal_hit |=> $stable(held_left));                              // R6

  AST_MUTE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(locked) |-> !sdata);                                       // R8

  AST_FRAME_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> $fell(bck));                                      // R10

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (!bck && !lrck && !sdata);             // R9
    end
  end
endmodule

bind aud_ser_fmt aud_ser_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bck         (bck),
  .lrck        (lrck),
  .sdata       (sdata),
  .locked      (locked),
  .fmt_sel     (fmt_sel),
  .frame_start (frame_start),
  .conceal_hit (conceal_hit),
  .held_left   (held_left)
);

// File: tb/sim_aud_ser_fmt.sv
module sim_aud_ser_fmt;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic [23:0] smp_left = '0;
  logic [23:0] smp_right = '0;
  logic        par_err = 1'b0;
  logic        non_pcm = 1'b0;
  logic        locked = 1'b1;
  logic [1:0]  fmt_sel = 2'b00;
  logic        bck, lrck, sdata;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  int cyc    = 0;
  int rise_cyc [3];
  bit done = 0;

  logic [63:0] q_dat [$];
  logic [63:0] q_lr  [$];
  string       q_tag [$];

  always #4 clk = ~clk;

  aud_ser_fmt #(.BCK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_left(smp_left),
    .smp_right(smp_right), .par_err(par_err), .non_pcm(non_pcm),
    .locked(locked), .fmt_sel(fmt_sel), .bck(bck), .lrck(lrck), .sdata(sdata)
  );

  function automatic logic [31:0] half_vec(logic [1:0] f, logic [23:0] w);
    case (f)
      2'b10:   return {w, 8'h00};          // R1
      2'b11:   return {1'b0, w, 7'h00};    // R2
      2'b01:   return {8'h00, w};          // R3
      default: return {16'h0000, w[23:8]}; // R3
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push_frame(logic [23:0] l, logic [23:0] r, logic lk, string tag);
    logic [63:0] d;
    d = {half_vec(fmt_sel, l), half_vec(fmt_sel, r)};
    q_dat.push_back(lk ? d : 64'h0);
    q_lr.push_back(fmt_sel == 2'b11 ? {32'h0, 32'hFFFF_FFFF}   // R5
                                    : {32'hFFFF_FFFF, 32'h0});
    q_tag.push_back(tag);
  endtask

  // monitor: slots captured at the rising bit clock, mid-bit
  initial begin
    logic        prev = 1'b0;
    logic        started = 1'b0;
    logic [63:0] cd = '0;
    logic [63:0] cl = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        started = 1'b0; rises = 0; prev = 1'b0;
      end else begin
        if (prev && !bck) started = 1'b1;
        if (!prev && bck && started) begin
          int p;
          p = rises % 64;
          cd[63-p] = sdata;
          cl[63-p] = lrck;
          if (rises < 3) rise_cyc[rises] = cyc;
          rises++;
          if (rises % 64 == 0) begin
            if (q_dat.size() == 0) begin
              checks++; fails++;
              $display("FAIL R10 actual=extra frame expected=no frame");
            end else begin
              string t;
              t = q_tag.pop_front();
              check({t, " data"}, cd, q_dat.pop_front());
              check({"R5 ", t, " word clock"}, cl, q_lr.pop_front());
            end
          end
        end
        prev = bck;
      end
    end
  end

  task automatic strobe(logic [23:0] l, logic [23:0] r, logic e, logic np);
    @(negedge clk);
    smp_stb = 1'b1; smp_left = l; smp_right = r; par_err = e; non_pcm = np;
    @(negedge clk);
    smp_stb = 1'b0; par_err = 1'b0; non_pcm = 1'b0;
  endtask

  task automatic run_fmt(logic [1:0] f, string ftag);
    logic [23:0] hl, hr;
    rst_n = 1'b0; fmt_sel = f; locked = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset outputs", {61'h0, bck, lrck, sdata}, 64'h0);
    hl = '0; hr = '0;
    push_frame(hl, hr, 1'b1, {"R9 ", ftag});
    rst_n = 1'b1;
    for (int fr = 0; fr < 5; fr++) begin
      logic nl;
      string tg;
      nl = 1'b1;
      wait (rises >= fr * 64 + 20);
      case (fr)
        0: begin strobe(24'h9A5C31, 24'hC3E7F1, 1'b0, 1'b0); hl = 24'h9A5C31; hr = 24'hC3E7F1; tg = ftag; end
        1: begin strobe(24'h123456, 24'h654321, 1'b1, 1'b0); tg = {"R6 ", ftag}; end // concealed
        2: begin strobe(24'hE01F80, 24'h7F00FE, 1'b1, 1'b1); hl = 24'hE01F80; hr = 24'h7F00FE; tg = {"R7 ", ftag}; end
        3: begin nl = 1'b0; tg = {"R8 ", ftag}; end
        default: begin
          strobe(24'h0F0F0F, 24'hF0F0F0, 1'b0, 1'b0);
          strobe(24'hA5A5A5, 24'h5A5A5A, 1'b0, 1'b0);
          hl = 24'hA5A5A5; hr = 24'h5A5A5A; tg = {"R10 ", ftag};
        end
      endcase
      wait (rises >= fr * 64 + 64);
      locked = nl;
      push_frame(hl, hr, nl, tg);
      if (!nl) begin
        @(negedge clk);
        check("R8 data low after lock loss", {63'h0, sdata}, 64'h0);
      end
    end
    wait (rises >= 6 * 64);
    repeat (4) @(negedge clk);
    check("R10 all frames seen", 64'(q_dat.size()), 64'h0);
  endtask

  initial begin
    run_fmt(2'b10, "R1");
    check("R4 bit clock period", 64'(rise_cyc[2] - rise_cyc[1]), 64'(DIV));
    run_fmt(2'b11, "R2");
    run_fmt(2'b01, "R3");
    run_fmt(2'b00, "R3");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule